// File: doc/BRIEF.md
# Byte-Aligned Fuse Word Reader

This block drives a one-time-programmable fuse macro whose read port returns one 32-bit word per strobe. A request names any byte offset and any byte length. The block widens that range to the whole words it touches, and reads each of those words with a single strobe in ascending word order. From the words it reads, it passes on only the bytes that were asked for. Bytes leave as a stream, one per cycle at most, with the lowest byte of each word first.

The macro is driven through one 32-bit control word. This word carries the single-bit control lines at fixed bit positions and the 10-bit word address in an upper field. Before the first strobe the block puts the macro into read mode and waits a settle time. After the last word, and also for an empty request, it returns the macro to power-down standby and pulses `doneO`. While a request is in flight, a new start is ignored.

Top module: `fuse_word_reader`

## Requirements
- R1: Out of reset, and whenever idle, `ctlWordO` is exactly 0x00000021, `busyO` is low, and `byteValidO` is low. The control-word encoding is: bit0 chip-select-bar, bit1 strobe, bit2 load, bit3 program-enable-bar, bit5 power-down, bit7 sense-bar, bit9 strobe-shift-select, bits 25:16 word address.
- R2: A request with nonzero length first enters read mode: load, program-enable-bar, sense-bar and strobe-shift-select go high and chip-select-bar and power-down go low. Read mode is held for exactly SETTLE_CYC cycles with strobe low before the first strobe.
- R3: The number of strobe pulses equals ceil((offset+length)/4) - floor(offset/4). The word address presented with each strobe starts at floor(offset/4) and rises by one per strobe.
- R4: Each strobe stays high for exactly STROBE_CYC cycles with a stable address, and the macro data is sampled in the last of those cycles.
- R5: After strobe falls, at least GAP_CYC cycles pass with strobe low before the next strobe.
- R6: Exactly `length` bytes come out on `byteDataO` with `byteValidO` high, never while strobe is high. Byte k equals bits [8j+7:8j] of the fuse word at address (offset+k)/4, where j = (offset+k) mod 4. The leading and trailing bytes of the edge words are dropped.
- R7: A zero-length request makes no strobe, leaves the control word in standby, keeps `busyO` low, and pulses `doneO` in the cycle after the start.
- R8: When the last word has been handled, the control word returns to standby (0x00000021), `busyO` falls, and `doneO` is high for exactly one cycle.
- R9: A start that arrives while `busyO` is high is ignored. It causes no extra strobes and no extra bytes.
- R10: Byte offsets wrap modulo 4096, so word addresses wrap from 1023 to 0 within a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startI | input | 1 | Start pulse for a request, taken only when idle |
| offsetI | input | 12 | Byte offset of the first requested byte |
| lengthI | input | 13 | Number of bytes requested |
| macroDataI | input | 32 | Word returned by the fuse macro |
| ctlWordO | output | 32 | Control lines and word address to the macro |
| byteValidO | output | 1 | A requested byte is on byteDataO |
| byteDataO | output | 8 | Requested byte |
| busyO | output | 1 | Request in progress |
| doneO | output | 1 | One-cycle pulse when a request completes |

## Verification
A wrong byte cursor shows up at the ports in two ways. The strobe count or the address sequence is wrong as soon as the second word is strobed, and the first delivered byte comes from the wrong lane one cycle after the first sample. A timer that is off by one changes how long read mode is held or how long a strobe is high, and this is visible at the very first strobe edge. A sampling point moved outside the strobe window makes the bench macro return a filler value, so the first byte of the stream is already wrong. A broken remaining-count shows up at completion as a stream that is too long or too short, or as a missing done pulse.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  // bit positions within the macro control word
  localparam int CsBarBit    = 0;
  localparam int StrobeBit   = 1;
  localparam int LoadBit     = 2;
  localparam int PgmBarBit   = 3;
  localparam int PwrDownBit  = 5;
  localparam int SenseBarBit = 7;
  localparam int StrbSelBit  = 9;
  localparam int AddrLsb     = 16;

  typedef struct packed {
    logic csBar;
    logic strobe;
    logic load;
    logic pgmBar;
    logic pwrDown;
    logic senseBar;
    logic strbSel;
  } fusePins_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic sampleWord;
    logic emitByte;
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ENTER,
    S_STROBE,
    S_EMIT,
    S_GAP
  } rdState_t;

endpackage

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int STROBE_CYC = 3,
  parameter int GAP_CYC    = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startI,
  input  logic      lenZeroI,
  input  logic      lastInWordI,
  input  logic      remZeroI,
  output fusePins_t pinsO,
  output dpCtl_t    dpCtlO,
  output logic      busyO,
  output logic      doneO
);

  localparam int MaxA  = (SETTLE_CYC > STROBE_CYC) ? SETTLE_CYC : STROBE_CYC;
  localparam int MaxC  = (MaxA > GAP_CYC) ? MaxA : GAP_CYC;
  localparam int TimW  = (MaxC < 2) ? 1 : $clog2(MaxC);
  localparam logic [TimW-1:0] SettleLd = TimW'(SETTLE_CYC - 1);
  localparam logic [TimW-1:0] StrobeLd = TimW'(STROBE_CYC - 1);
  localparam logic [TimW-1:0] GapLd    = TimW'(GAP_CYC - 1);

  rdState_t        state;
  logic [TimW-1:0] timer;
  logic            timerZero;

  assign timerZero = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      timer <= '0;
      doneO <= 1'b0;
    end else begin
      doneO <= 1'b0;
      case (state)
        S_IDLE: begin
          if (startI) begin
            if (lenZeroI) begin
              doneO <= 1'b1;
            end else begin
              state <= S_ENTER;
              timer <= SettleLd;
            end
          end
        end
        S_ENTER: begin
          if (timerZero) begin
            state <= S_STROBE;
            timer <= StrobeLd;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_STROBE: begin
          if (timerZero) begin
            state <= S_EMIT;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_EMIT: begin
          if (lastInWordI) begin
            state <= S_GAP;
            timer <= GapLd;
          end
        end
        S_GAP: begin
          if (timerZero) begin
            if (remZeroI) begin
              state <= S_IDLE;
              doneO <= 1'b1;
            end else begin
              state <= S_STROBE;
              timer <= StrobeLd;
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtlO.loadReq    = (state == S_IDLE) && startI && !lenZeroI;
    dpCtlO.sampleWord = (state == S_STROBE) && timerZero;
    dpCtlO.emitByte   = (state == S_EMIT);
  end

  always_comb begin
    pinsO = '0;
    if (state == S_IDLE) begin
      pinsO.pwrDown = 1'b1;
      pinsO.csBar   = 1'b1;
    end else begin
      pinsO.load     = 1'b1;
      pinsO.pgmBar   = 1'b1;
      pinsO.senseBar = 1'b1;
      pinsO.strbSel  = 1'b1;
      pinsO.strobe   = (state == S_STROBE);
    end
  end

  assign busyO = (state != S_IDLE);

endmodule

// File: rtl/fuse_rd_dpath.sv
module fuse_rd_dpath
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               dpCtlI,
  input  logic [ADDR_W+$clog2(DATA_W/8)-1:0] offsetI,
  input  logic [LEN_W-1:0]     lengthI,
  input  logic [DATA_W-1:0]    macroDataI,
  output logic [ADDR_W-1:0]    wordAddrO,
  output logic                 lastInWordO,
  output logic                 remZeroO,
  output logic                 byteValidO,
  output logic [7:0]           byteDataO
);

  localparam int Lanes  = DATA_W / 8;
  localparam int LaneW  = $clog2(Lanes);
  localparam int OffW   = ADDR_W + LaneW;

  logic [OffW-1:0]   curByte;
  logic [LEN_W-1:0]  remaining;
  logic [DATA_W-1:0] wordReg;
  logic [LaneW-1:0]  lane;
  logic [7:0]        laneByte [Lanes];

  assign lane = curByte[LaneW-1:0];

  // split the held word into byte lanes, lowest lane = least significant byte
  for (genvar g = 0; g < Lanes; g++) begin : g_lane
    assign laneByte[g] = wordReg[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curByte    <= '0;
      remaining  <= '0;
      wordReg    <= '0;
      byteValidO <= 1'b0;
      byteDataO  <= '0;
    end else begin
      byteValidO <= 1'b0;
      if (dpCtlI.loadReq) begin
        curByte   <= offsetI;
        remaining <= lengthI;
      end
      if (dpCtlI.sampleWord) begin
        wordReg <= macroDataI;
      end
      if (dpCtlI.emitByte) begin
        byteDataO  <= laneByte[lane];
        byteValidO <= 1'b1;
        curByte    <= curByte + 1'b1;
        remaining  <= remaining - 1'b1;
      end
    end
  end

  assign wordAddrO   = curByte[OffW-1:LaneW];
  assign lastInWordO = (remaining == LEN_W'(1)) || (lane == LaneW'(Lanes - 1));
  assign remZeroO    = (remaining == '0);

endmodule

// File: rtl/fuse_word_reader.sv
module fuse_word_reader
  import fuse_rd_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int STROBE_CYC = 3,
  parameter int GAP_CYC    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startI,
  input  logic [11:0] offsetI,
  input  logic [12:0] lengthI,
  input  logic [31:0] macroDataI,
  output logic [31:0] ctlWordO,
  output logic        byteValidO,
  output logic [7:0]  byteDataO,
  output logic        busyO,
  output logic        doneO
);

  localparam int AddrW = 10;
  localparam int DataW = 32;
  localparam int LenW  = 13;

  fusePins_t        pins;
  dpCtl_t           dpCtl;
  logic [AddrW-1:0] wordAddr;
  logic             lastInWord;
  logic             remZero;

  fuse_rd_ctrl #(
    .SETTLE_CYC(SETTLE_CYC),
    .STROBE_CYC(STROBE_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startI     (startI),
    .lenZeroI   (lengthI == '0),
    .lastInWordI(lastInWord),
    .remZeroI   (remZero),
    .pinsO      (pins),
    .dpCtlO     (dpCtl),
    .busyO      (busyO),
    .doneO      (doneO)
  );

  fuse_rd_dpath #(
    .ADDR_W(AddrW),
    .DATA_W(DataW),
    .LEN_W (LenW)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtlI     (dpCtl),
    .offsetI    (offsetI),
    .lengthI    (lengthI),
    .macroDataI (macroDataI),
    .wordAddrO  (wordAddr),
    .lastInWordO(lastInWord),
    .remZeroO   (remZero),
    .byteValidO (byteValidO),
    .byteDataO  (byteDataO)
  );

  // pack pins and address into the macro control word; address is zero in standby
  always_comb begin
    ctlWordO              = '0;
    ctlWordO[CsBarBit]    = pins.csBar;
    ctlWordO[StrobeBit]   = pins.strobe;
    ctlWordO[LoadBit]     = pins.load;
    ctlWordO[PgmBarBit]   = pins.pgmBar;
    ctlWordO[PwrDownBit]  = pins.pwrDown;
    ctlWordO[SenseBarBit] = pins.senseBar;
    ctlWordO[StrbSelBit]  = pins.strbSel;
    if (!pins.pwrDown) begin
      ctlWordO[AddrLsb +: AddrW] = wordAddr;
    end
  end

endmodule

// File: rtl/fuse_rd_checker.sv
module fuse_rd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        startI,
  input logic [12:0] lengthI,
  input logic [31:0] ctlWordO,
  input logic        byteValidO,
  input logic        busyO,
  input logic        doneO
);

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busyO |-> (ctlWordO == 32'h0000_0021) && !byteValidO);

  p_strobe_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctlWordO[1] |-> ctlWordO[2] && ctlWordO[3] && ctlWordO[7] && ctlWordO[9]
                    && !ctlWordO[0] && !ctlWordO[5]);

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctlWordO[1] && $past(ctlWordO[1]) |-> $stable(ctlWordO[25:16]));

  p_byte_off_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    byteValidO |-> !ctlWordO[1] && busyO);

  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    startI && !busyO && (lengthI == '0) |=> doneO && !busyO);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> !busyO ##1 !doneO);

endmodule

bind fuse_word_reader fuse_rd_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startI    (startI),
  .lengthI   (lengthI),
  .ctlWordO  (ctlWordO),
  .byteValidO(byteValidO),
  .busyO     (busyO),
  .doneO     (doneO)
);

// File: tb/tb_fuse_word_reader.sv
`timescale 1ns/1ps
module tb_fuse_word_reader;

  localparam int SETTLE = 4;
  localparam int STRB   = 3;
  localparam int GAP    = 2;
  localparam int NVEC   = 8;
  localparam int VEC [0:NVEC-1][0:1] = '{
    '{0, 4}, '{1, 1}, '{3, 2}, '{2, 9},
    '{5, 3}, '{0, 16}, '{7, 13}, '{4094, 4}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic [11:0] offsetI = '0;
  logic [12:0] lengthI = '0;
  logic [31:0] macroDataI;
  logic [31:0] ctlWordO;
  logic        byteValidO;
  logic [7:0]  byteDataO;
  logic        busyO;
  logic        doneO;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  fuse_word_reader #(.SETTLE_CYC(SETTLE), .STROBE_CYC(STRB), .GAP_CYC(GAP)) dut (
    .clk(clk), .rstN(rstN), .startI(startI), .offsetI(offsetI), .lengthI(lengthI),
    .macroDataI(macroDataI), .ctlWordO(ctlWordO), .byteValidO(byteValidO),
    .byteDataO(byteDataO), .busyO(busyO), .doneO(doneO)
  );

  function automatic logic [7:0] byteAt(int b);
    return 8'((b * 37 + 11) ^ (b >> 5));
  endfunction

  function automatic logic [31:0] fuseWord(int a);
    return {byteAt(a*4+3), byteAt(a*4+2), byteAt(a*4+1), byteAt(a*4)};
  endfunction

  // macro model: valid data only while strobed in read mode
  always_comb begin
    if (ctlWordO[1] && ctlWordO[7] && !ctlWordO[0])
      macroDataI = fuseWord(int'(ctlWordO[25:16]));
    else
      macroDataI = 32'hDEAD_BEEF;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor state
  logic [7:0] got [0:63];
  int  gotN = 0;
  int  strobeCnt = 0;
  int  expAddr = 0;
  bit  firstStrobe = 0;
  bit  doneSeen = 0;
  int  hiCnt = 0, loCnt = 0, setCnt = 0;
  bit  prevStrobe = 0, prevLoad = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (doneO) doneSeen = 1;
      if (byteValidO) begin
        if (gotN < 64) got[gotN] = byteDataO;
        gotN++;
      end
      if (ctlWordO[2] && !prevLoad) begin
        chk(ctlWordO[3] && ctlWordO[7] && ctlWordO[9] && !ctlWordO[0] && !ctlWordO[5],
            "R2 read-mode pins", ctlWordO, 32'h28C);
        setCnt = 0;
      end
      if (ctlWordO[1] && !prevStrobe) begin
        strobeCnt++;
        chk(int'(ctlWordO[25:16]) == expAddr, "R3 word address", ctlWordO[25:16], expAddr);
        expAddr = (expAddr + 1) % 1024;
        if (firstStrobe) chk(setCnt == SETTLE, "R2 settle length", setCnt, SETTLE);
        else             chk(loCnt >= GAP, "R5 gap length", loCnt, GAP);
        firstStrobe = 0;
        hiCnt = 1;
      end else if (ctlWordO[1]) begin
        hiCnt++;
      end
      if (!ctlWordO[1] && prevStrobe) begin
        chk(hiCnt == STRB, "R4 strobe width", hiCnt, STRB);
        loCnt = 1;
      end else if (!ctlWordO[1]) begin
        loCnt++;
      end
      if (ctlWordO[2] && !ctlWordO[1] && firstStrobe) setCnt++;
      prevStrobe = ctlWordO[1];
      prevLoad   = ctlWordO[2];
    end
  end

  task automatic issue(input int off, input int len);
    gotN = 0; strobeCnt = 0; doneSeen = 0;
    firstStrobe = 1; expAddr = (off >> 2) % 1024;
    @(negedge clk);
    startI = 1'b1; offsetI = 12'(off); lengthI = 13'(len);
    @(negedge clk);
    startI = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000 && !doneSeen; i++) @(negedge clk);
  endtask

  task automatic checkResult(input int off, input int len);
    int bad = 0;
    int firstBad = -1;
    int expWords;
    expWords = (len == 0) ? 0 : ((off + len + 3) >> 2) - (off >> 2);
    chk(doneSeen, "R8 done pulse", doneSeen, 1);
    chk(gotN == len, "R6 byte count", gotN, len);
    for (int k = 0; k < len && k < gotN && k < 64; k++) begin
      if (got[k] !== byteAt((off + k) % 4096)) begin
        bad++;
        if (firstBad < 0) firstBad = k;
      end
    end
    if (firstBad >= 0)
      chk(0, "R6 byte value", got[firstBad], byteAt((off + firstBad) % 4096));
    else
      chk(1, "R6 byte value", 0, 0);
    chk(strobeCnt == expWords, "R3 strobe count", strobeCnt, expWords);
    chk(ctlWordO == 32'h21 && !busyO, "R8 standby after completion", ctlWordO, 32'h21);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ctlWordO == 32'h21, "R1 reset control word", ctlWordO, 32'h21);
    chk(!busyO && !byteValidO && !doneO, "R1 reset outputs", {busyO, byteValidO, doneO}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(ctlWordO == 32'h21, "R1 idle control word", ctlWordO, 32'h21);

    // table walk: R2..R6, R8, last entry wraps addresses (R10)
    for (int v = 0; v < NVEC; v++) begin
      issue(VEC[v][0], VEC[v][1]);
      waitDone();
      @(negedge clk);
      checkResult(VEC[v][0], VEC[v][1]);
    end

    // R10: address wrap explicitly visible
    issue(4092, 8);
    waitDone();
    @(negedge clk);
    checkResult(4092, 8);
    chk(expAddr == 1, "R10 wrapped address sequence", expAddr, 1);

    // R7: zero-length request
    gotN = 0; strobeCnt = 0; doneSeen = 0; firstStrobe = 1;
    @(negedge clk);
    startI = 1'b1; offsetI = 12'd9; lengthI = 13'd0;
    @(negedge clk);
    startI = 1'b0;
    chk(doneO && !busyO, "R7 done in next cycle", {doneO, busyO}, 2'b10);
    chk(ctlWordO == 32'h21, "R7 standby kept", ctlWordO, 32'h21);
    repeat (4) @(negedge clk);
    chk(strobeCnt == 0 && gotN == 0, "R7 no strobe or bytes", strobeCnt + gotN, 0);

    // R9: start while busy ignored
    issue(1, 8);
    repeat (6) @(negedge clk);
    startI = 1'b1; offsetI = 12'd200; lengthI = 13'd4;
    @(negedge clk);
    startI = 1'b0; offsetI = 12'd0;
    waitDone();
    @(negedge clk);
    checkResult(1, 8);
    doneSeen = 0;
    repeat (40) @(negedge clk);
    chk(gotN == 8 && strobeCnt == 3 && !doneSeen && !busyO, "R9 second start ignored",
        gotN, 8);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule